// File: doc/BRIEF.md
# Backplane I/O Interface Control Logic

This block is the control and status logic of one peripheral interface card on a 16-bit minicomputer I/O backplane. Each I/O cycle is marked by a one-clock strobe. During that cycle the CPU presents a 6-bit select code, a bus of one-hot inbound signals and a 16-bit write word. The block holds a control flip-flop, a flag flip-flop, a flag-buffer flip-flop and a 16-bit data register. It returns a skip indication, read data, a priority-low output, an interrupt-request output and a service-request output.

The card compares the select code with its own code, which is set by a parameter. Addressed signals act only on a match. Power-up, preset, control-reset, flag-enable and interrupt-sample are broadcast to every card, so they act whatever the select code is. When one cycle carries several signals, they are applied in ascending order of their bit number. Each signal sees the state left by the signals below it. All outputs are registered and are valid in the clock after the strobe.

Top module: `io_card_ctl`

## Requirements
- R1: After reset, prio_low is 1 and irq, srq, skip and rd_data are all 0.
- R2: Addressed signals (bits 2..10 and 13) have no effect when sel_code differs from CARD_CODE. Broadcast signals (bits 0, 1, 11, 12, 14) act on any select code.
- R3: Bit 3 (write) loads wr_data into the data register. Bit 2 (read) presents the register on rd_data for the one clock after the strobe; at all other times rd_data is 0. Read and write in the same cycle return the old register value.
- R4: skip is 1 for the one clock after a cycle that carries bit 4 (skip-if-set) while the flag is 1, or bit 5 (skip-if-clear) while the flag is 0. At all other times skip is 0. The tests see the flag before a clear-flag (bit 9) in the same cycle.
- R5: Bit 8 sets the flag and the flag buffer. Bit 9 clears both. srq always equals the flag.
- R6: Bit 6 sets control and bit 7 clears it, with bit 7 winning when both arrive. prio_low equals NOT(control AND flag). A control operation combined with bit 9 gives the same result as the two applied one after the other.
- R7: Bit 1 (flag-enable) sets the flag only when the flag buffer is already set. Bit 13 (interrupt acknowledge) clears the flag buffer only. A one-clock pulse on dev_done sets the flag buffer only.
- R8: irq is loaded with control AND flag AND flag-buffer only in a cycle carrying bit 14. The value is taken after every lower-numbered signal of that cycle. Otherwise irq holds its value.
- R9: Bit 11 (control reset) clears control. Bit 12 (preset) sets the flag and the flag buffer. Bit 0 (power-up) clears the data register. The power-up set of bits 0, 11 and 12 together gives: control clear, flag set and data zero.
- R10: dev_done is applied before the bus signals of the same clock, so a clear-flag in that cycle overrides it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stb | input | 1 | One-clock I/O cycle strobe |
| sel_code | input | 6 | Select code of the current cycle |
| sig | input | 15 | Inbound backplane signals, bit numbers as in the requirements |
| wr_data | input | 16 | Word from the CPU for a write |
| dev_done | input | 1 | Device completion pulse |
| rd_data | output | 16 | Word to the CPU for a read, else zero |
| skip | output | 1 | Skip indication for the cycle just finished |
| prio_low | output | 1 | Priority-low, NOT(control AND flag) |
| irq | output | 1 | Interrupt request |
| srq | output | 1 | Service request, equals the flag |

## Verification
The checker assumes that sig, sel_code, wr_data and dev_done are only meaningful while stb is high or dev_done is pulsed. It also assumes that they are stable around each rising edge, so every property is written as one strobed cycle followed by its result in the next clock. The bench drives all inputs on the falling edge and holds the strobe for exactly one clock. It samples on the next falling edge and uses combined-signal cycles to reach the ordering corners. These corners are skip with clear-flag, read with write, acknowledge with interrupt sample, and device done with clear-flag.

// File: rtl/io_card_ctl.sv
module io_card_ctl #(
  parameter int        DW        = 16,
  parameter int        SCW       = 6,
  parameter int        NSIG      = 15,
  parameter bit [5:0]  CARD_CODE = 6'd8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stb,
  input  logic [SCW-1:0]  sel_code,
  input  logic [NSIG-1:0] sig,
  input  logic [DW-1:0]   wr_data,
  input  logic            dev_done,
  output logic [DW-1:0]   rd_data,
  output logic            skip,
  output logic            prio_low,
  output logic            irq,
  output logic            srq
);
  localparam int PWRUP = 0, FENA = 1, RDRQ = 2, WRRQ = 3, SKSET = 4, SKCLR = 5;
  localparam int CTLSET = 6, CTLCLR = 7, FLGSET = 8, FLGCLR = 9, XFEND = 10;
  localparam int CTLRST = 11, PRESET = 12, INTACK = 13, IRQSMP = 14;
  localparam logic [NSIG-1:0] BCAST = NSIG'((1 << PWRUP) | (1 << FENA) |
                                            (1 << CTLRST) | (1 << PRESET) | (1 << IRQSMP));

  logic          ctl, flag, fbuf, irq_q, skip_q;
  logic [DW-1:0] dreg, rd_q;
  logic          n_ctl, n_flag, n_fbuf, n_irq, n_skip;
  logic [DW-1:0] n_dreg, n_rd;
  logic [NSIG-1:0] g;

  assign g = stb ? (sig & ((sel_code == CARD_CODE[SCW-1:0]) ? {NSIG{1'b1}} : BCAST))
                 : '0;

  always_comb begin
    n_ctl  = ctl;
    n_flag = flag;
    n_fbuf = fbuf | dev_done;
    n_dreg = dreg;
    n_irq  = irq_q;
    n_skip = 1'b0;
    n_rd   = '0;
    if (g[PWRUP])                n_dreg = '0;
    if (g[FENA] && n_fbuf)       n_flag = 1'b1;
    if (g[RDRQ])                 n_rd   = n_dreg;
    if (g[WRRQ])                 n_dreg = wr_data;
    if (g[SKSET] && n_flag)      n_skip = 1'b1;
    if (g[SKCLR] && !n_flag)     n_skip = 1'b1;
    if (g[CTLSET])               n_ctl  = 1'b1;
    if (g[CTLCLR])               n_ctl  = 1'b0;
    if (g[FLGSET]) begin n_fbuf = 1'b1; n_flag = 1'b1; end
    if (g[FLGCLR]) begin n_fbuf = 1'b0; n_flag = 1'b0; end
    if (g[XFEND])                n_ctl  = n_ctl;
    if (g[CTLRST])               n_ctl  = 1'b0;
    if (g[PRESET]) begin n_fbuf = 1'b1; n_flag = 1'b1; end
    if (g[INTACK])               n_fbuf = 1'b0;
    if (g[IRQSMP])               n_irq  = n_ctl & n_flag & n_fbuf;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl    <= 1'b0;
      flag   <= 1'b0;
      fbuf   <= 1'b0;
      dreg   <= '0;
      irq_q  <= 1'b0;
      skip_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      ctl    <= n_ctl;
      flag   <= n_flag;
      fbuf   <= n_fbuf;
      dreg   <= n_dreg;
      irq_q  <= n_irq;
      skip_q <= n_skip;
      rd_q   <= n_rd;
    end
  end

  assign rd_data  = rd_q;
  assign skip     = skip_q;
  assign prio_low = ~(ctl & flag);
  assign irq      = irq_q;
  assign srq      = flag;
endmodule

// File: rtl/io_card_ctl_chk.sv
module io_card_ctl_chk #(
  parameter int        DW        = 16,
  parameter int        SCW       = 6,
  parameter int        NSIG      = 15,
  parameter bit [5:0]  CARD_CODE = 6'd8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stb,
  input logic [SCW-1:0]  sel_code,
  input logic [NSIG-1:0] sig,
  input logic [DW-1:0]   rd_data,
  input logic            skip,
  input logic            prio_low,
  input logic            irq,
  input logic            srq
);
  logic hit;
  assign hit = stb && (sel_code == CARD_CODE[SCW-1:0]);

  a_r4_skip_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> !skip);
  a_r3_rd_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && sig[2]) |=> rd_data == '0);
  a_r5_set_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && sig[8] && !sig[9]) |=> srq);
  a_r6_prio_vs_srq: assert property (@(posedge clk) disable iff (!rst_n)
    !srq |-> prio_low);
  a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb && sig[14]) |=> $stable(irq));
  a_r9_ctl_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && sig[11]) |=> prio_low);
endmodule

bind io_card_ctl io_card_ctl_chk #(.DW(DW), .SCW(SCW), .NSIG(NSIG), .CARD_CODE(CARD_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .stb(stb), .sel_code(sel_code), .sig(sig),
  .rd_data(rd_data), .skip(skip), .prio_low(prio_low), .irq(irq), .srq(srq));

// File: tb/io_card_ctl_bench.sv
module io_card_ctl_bench;
  localparam logic [5:0] ME = 6'd8, OTHER = 6'd21;
  localparam logic [14:0] PWR = 15'h0001, ENF = 15'h0002, RD = 15'h0004, WR = 15'h0008,
    SKS = 15'h0010, SKC = 15'h0020, STC = 15'h0040, CLC = 15'h0080, STF = 15'h0100,
    CLF = 15'h0200, CRS = 15'h0800, PRE = 15'h1000, IAK = 15'h2000, SIR = 15'h4000;

  logic clk = 0, rst_n = 0, stb = 0, dev_done = 0;
  logic [5:0] sel_code = '0;
  logic [14:0] sig = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic skip, prio_low, irq, srq;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  io_card_ctl u_io_card_ctl (.clk(clk), .rst_n(rst_n), .stb(stb), .sel_code(sel_code),
    .sig(sig), .wr_data(wr_data), .dev_done(dev_done), .rd_data(rd_data), .skip(skip),
    .prio_low(prio_low), .irq(irq), .srq(srq));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [5:0] sc, input logic [14:0] s, input logic [15:0] w = '0,
                     input logic done = 1'b0);
    @(negedge clk);
    stb = 1; sel_code = sc; sig = s; wr_data = w; dev_done = done;
    @(negedge clk);
    stb = 0; sig = '0; dev_done = 0;
  endtask

  task automatic t_reset;
    chk("R1 prio_low", 16'(prio_low), 1);
    chk("R1 irq", 16'(irq), 0);
    chk("R1 srq", 16'(srq), 0);
    chk("R1 skip", 16'(skip), 0);
    chk("R1 rd_data", rd_data, 0);
  endtask

  task automatic t_select;
    cyc(OTHER, STF);        chk("R2 STF other code", 16'(srq), 0);
    cyc(OTHER, WR, 16'hBEEF);
    cyc(ME, RD);            chk("R2 WR other code", rd_data, 0);
  endtask

  task automatic t_data;
    cyc(ME, WR, 16'hA5C3);
    cyc(ME, RD);            chk("R3 read", rd_data, 16'hA5C3);
    @(negedge clk);         chk("R3 idle zero", rd_data, 0);
    cyc(ME, RD | WR, 16'h1234); chk("R3 read old on rd+wr", rd_data, 16'hA5C3);
    cyc(ME, RD);            chk("R3 read new", rd_data, 16'h1234);
  endtask

  task automatic t_skip_flag;
    cyc(ME, STF);           chk("R5 srq after STF", 16'(srq), 1);
    cyc(ME, SKS);           chk("R4 skip set", 16'(skip), 1);
    @(negedge clk);         chk("R4 skip one clock", 16'(skip), 0);
    cyc(ME, SKC);           chk("R4 no skip clear", 16'(skip), 0);
    cyc(ME, SKS | CLF);     chk("R4 skip before clear", 16'(skip), 1);
                            chk("R5 srq after CLF", 16'(srq), 0);
    cyc(ME, SKC);           chk("R4 skip clear", 16'(skip), 1);
    cyc(ME, SKS);           chk("R4 no skip set", 16'(skip), 0);
  endtask

  task automatic t_control;
    cyc(ME, STC);           chk("R6 prio flag0", 16'(prio_low), 1);
    cyc(ME, STF);           chk("R6 prio ctl&flag", 16'(prio_low), 0);
    cyc(ME, CLC);           chk("R6 CLC", 16'(prio_low), 1);
    cyc(ME, STC | CLF);     chk("R6 STC+CLF flag", 16'(srq), 0);
    cyc(ME, STF);           chk("R6 STC+CLF ctl kept", 16'(prio_low), 0);
    cyc(ME, STC | CLC);     chk("R6 CLC wins", 16'(prio_low), 1);
  endtask

  task automatic t_enable;
    cyc(ME, CLF);
    @(negedge clk); dev_done = 1; @(negedge clk); dev_done = 0;
    chk("R7 done sets buffer only", 16'(srq), 0);
    cyc(OTHER, ENF);        chk("R7 ENF with buffer", 16'(srq), 1);
    cyc(ME, IAK);           chk("R7 IAK keeps flag", 16'(srq), 1);
    cyc(ME, CLF);
    cyc(ME, ENF);           chk("R7 ENF no buffer", 16'(srq), 0);
    cyc(ME, CLF, '0, 1'b1);
    cyc(ME, ENF);           chk("R10 CLF overrides done", 16'(srq), 0);
  endtask

  task automatic t_irq;
    cyc(ME, STC); cyc(ME, STF);
    cyc(OTHER, SIR);        chk("R8 irq set", 16'(irq), 1);
    cyc(ME, CLF);           chk("R8 irq holds", 16'(irq), 1);
    cyc(ME, SIR);           chk("R8 irq resample", 16'(irq), 0);
    cyc(ME, STF); cyc(ME, SIR); chk("R8 irq again", 16'(irq), 1);
    cyc(ME, IAK | SIR);     chk("R8 IAK before SIR", 16'(irq), 0);
  endtask

  task automatic t_reset_signals;
    cyc(ME, STC); cyc(ME, STF);
    cyc(OTHER, CRS);        chk("R9 CRS broadcast", 16'(prio_low), 1);
    cyc(ME, WR, 16'h7777); cyc(ME, CLF); cyc(ME, STC);
    cyc(OTHER, PWR | PRE | CRS);
    chk("R9 power-up flag", 16'(srq), 1);
    chk("R9 power-up ctl", 16'(prio_low), 1);
    cyc(ME, RD);            chk("R9 power-up data", rd_data, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset; t_select; t_data; t_skip_flag; t_control; t_enable; t_irq; t_reset_signals;
      end
      begin
        repeat (5000) @(negedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule